// File: doc/BRIEF.md
# Snooping Coherence Line Controller

This block keeps the coherence state and the tag of every line in a small direct-mapped cache attached to a shared snooping bus. Each line is Invalid, Shared (clean, read only) or Exclusive (dirty, read/write). Local CPU reads and writes are looked up against the resident tag. Hits are answered at once. Misses become read-miss or write-miss requests on the bus. A dirty victim is first handed to a write-back port.

At the same time the block watches read-miss and write-miss transactions that other caches place on the bus. A snoop that hits a Shared line with a write miss invalidates that line. A snoop that hits an Exclusive line makes this cache supply the dirty block: it pulses an abort to memory together with the block's address, and the line is downgraded to Shared (read miss) or Invalid (write miss).

Only tags, states and control are held here. Data storage, bus arbitration and memory sit outside. A victim write-back whose line has already been flushed by a snoop is withdrawn and not presented again.

Top module: `coh_line_ctl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high when no snoop is present, and `cpu_resp_valid`, `bus_req_valid`, `wb_valid` and `snp_abort` are low, with `snp_flush_addr` zero.
- R2: A CPU read whose address is not resident (line Invalid, or line clean with another tag) raises `bus_req_valid` with `bus_req_write`=0 and `bus_req_addr` equal to the request address. On `bus_done` the line takes the new tag in state Shared.
- R3: A CPU write to a line that is Invalid, Shared with the same tag, or clean with another tag raises `bus_req_valid` with `bus_req_write`=1 and the request address. On `bus_done` the line becomes Exclusive with the new tag.
- R4: A read hit (Shared or Exclusive, same tag) or a write hit (Exclusive, same tag) gives `cpu_resp_valid`=1 and `cpu_resp_hit`=1 in the cycle after acceptance, with no bus or write-back request.
- R5: A CPU miss on an Exclusive line with another tag first raises `wb_valid` with `wb_addr` = {old tag, index}, held until `wb_ack`. Only then does it raise the bus request of the miss kind; a read ends Shared and a write ends Exclusive.
- R6: A snooped write miss (`snp_write`=1) whose tag matches a Shared line makes the line Invalid without an abort.
- R7: A snooped read miss (`snp_write`=0) whose tag matches an Exclusive line pulses `snp_abort` for one cycle in the cycle after the snoop, with `snp_flush_addr` equal to the snooped address, and leaves the line Shared.
- R8: A snooped write miss whose tag matches an Exclusive line pulses `snp_abort` the same way and leaves the line Invalid.
- R9: A snoop to an Invalid line, to a line with another tag, or a snooped read miss to a Shared line changes no state and gives no abort.
- R10: `cpu_ready` is high only while the controller is idle and `snp_valid` is low, and a request is taken only then. The bus request stays asserted and stable until `bus_done`, and the miss response (`cpu_resp_hit`=0) comes in the cycle after `bus_done`.
- R11: At most one of `cpu_resp_valid`, `bus_req_valid` and `wb_valid` is high in any cycle, and `cpu_resp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | CPU block address (low bits index the line) |
| cpu_ready | output | 1 | Request taken at this edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion of the request |
| cpu_resp_hit | output | 1 | Completion was a hit |
| bus_req_valid | output | 1 | Miss transaction requested on the bus |
| bus_req_write | output | 1 | 1 = write miss, 0 = read miss |
| bus_req_addr | output | ADDR_W | Address of the miss |
| bus_done | input | 1 | Bus transaction granted and completed |
| wb_valid | output | 1 | Victim write-back requested |
| wb_addr | output | ADDR_W | Victim block address |
| wb_ack | input | 1 | Write-back accepted |
| snp_valid | input | 1 | Foreign miss observed on the bus |
| snp_write | input | 1 | 1 = write miss, 0 = read miss |
| snp_addr | input | ADDR_W | Address of the foreign miss |
| snp_abort | output | 1 | Abort the memory access; this cache supplies the block |
| snp_flush_addr | output | ADDR_W | Address of the block being supplied |

## Verification
The bench builds the block with a 6-bit address and four lines, which gives 2 index bits and 4 tag bits. It draws tags from three values, so hits, same-index conflicts and tag mismatches all occur often. Several hundred mixed CPU reads, CPU writes and snoops of both kinds drive every line through every state and every event. A bench-side state table predicts each hit, write-back address, bus request and abort. Grant and acknowledge delays vary between zero and two cycles, which exercises the holding and withholding rules.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHD = 2'd1,
      LS_EXC = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_WB   = 2'd1,
      CS_BUS  = 2'd2,
      CS_RESP = 2'd3
   } ctl_st_t;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
   import coh_pkg::*;
#(
   parameter int LINES = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output line_st_t         rd_a_st,
   output logic [TAG_W-1:0] rd_a_tag,
   input  logic [IDX_W-1:0] rd_b_idx,
   output line_st_t         rd_b_st,
   output logic [TAG_W-1:0] rd_b_tag,
   input  logic             snp_we,
   input  logic [IDX_W-1:0] snp_idx,
   input  line_st_t         snp_st,
   input  logic             cpu_we,
   input  logic [IDX_W-1:0] cpu_idx,
   input  line_st_t         cpu_st,
   input  logic [TAG_W-1:0] cpu_tag
);

   line_st_t         st_v  [LINES];
   logic [TAG_W-1:0] tag_v [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_t         st_r;
      logic [TAG_W-1:0] tag_r;
      logic             cpu_sel;
      logic             snp_sel;

      assign cpu_sel = cpu_we && (cpu_idx == IDX_W'(i));
      assign snp_sel = snp_we && (snp_idx == IDX_W'(i));

      // the CPU-side install or write-back completion takes precedence
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
         end else if (cpu_sel) begin
            st_r  <= cpu_st;
            tag_r <= cpu_tag;
         end else if (snp_sel) begin
            st_r  <= snp_st;
         end
      end

      assign st_v[i]  = st_r;
      assign tag_v[i] = tag_r;
   end

   assign rd_a_st  = st_v[rd_a_idx];
   assign rd_a_tag = tag_v[rd_a_idx];
   assign rd_b_st  = st_v[rd_b_idx];
   assign rd_b_tag = tag_v[rd_b_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   input  line_st_t          line_st,
   input  logic [TAG_W-1:0]  line_tag,
   output logic              upd_we,
   output logic [IDX_W-1:0]  upd_idx,
   output line_st_t          upd_st,
   output logic              snp_abort,
   output logic [ADDR_W-1:0] snp_flush_addr
);

   logic tag_match;
   logic flush;

   assign upd_idx   = snp_addr[IDX_W-1:0];
   assign tag_match = snp_valid && (line_st != LS_INV) &&
                      (line_tag == snp_addr[ADDR_W-1:IDX_W]);

   always_comb begin
      upd_we = 1'b0;
      upd_st = line_st;
      flush  = 1'b0;
      if (tag_match) begin
         case (line_st)
            LS_EXC: begin
               upd_we = 1'b1;
               flush  = 1'b1;
               upd_st = snp_write ? LS_INV : LS_SHD;
            end
            LS_SHD: begin
               if (snp_write) begin
                  upd_we = 1'b1;
                  upd_st = LS_INV;
               end
            end
            default: begin
               upd_we = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_abort      <= 1'b0;
         snp_flush_addr <= '0;
      end else begin
         snp_abort <= flush;
         if (flush) snp_flush_addr <= snp_addr;
      end
   end

endmodule

// File: rtl/coh_cpu_ctl.sv
module coh_cpu_ctl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_ready,
   output logic              cpu_resp_valid,
   output logic              cpu_resp_hit,
   output logic              bus_req_valid,
   output logic              bus_req_write,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_done,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack,
   input  logic              snp_valid,
   output logic [IDX_W-1:0]  look_idx,
   input  line_st_t          line_st,
   input  logic [TAG_W-1:0]  line_tag,
   output logic              upd_we,
   output logic [IDX_W-1:0]  upd_idx,
   output line_st_t          upd_st,
   output logic [TAG_W-1:0]  upd_tag
);

   ctl_st_t           st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic              hit_q;
   logic [TAG_W-1:0]  vic_tag_q;

   logic              accept;
   logic              tag_eq;
   logic              is_hit;
   logic              dirty_vic;
   logic              vic_live;

   assign cpu_ready = (st_q == CS_IDLE) && !snp_valid;
   assign accept    = cpu_ready && cpu_req_valid;
   assign look_idx  = (st_q == CS_IDLE) ? cpu_req_addr[IDX_W-1:0]
                                        : addr_q[IDX_W-1:0];

   assign tag_eq    = (line_tag == cpu_req_addr[ADDR_W-1:IDX_W]);
   assign is_hit    = (line_st != LS_INV) && tag_eq &&
                      (!cpu_req_write || (line_st == LS_EXC));
   assign dirty_vic = (line_st == LS_EXC) && !tag_eq;
   assign vic_live  = (line_st == LS_EXC) && (line_tag == vic_tag_q);

   assign wb_valid       = (st_q == CS_WB) && vic_live;
   assign wb_addr        = {vic_tag_q, addr_q[IDX_W-1:0]};
   assign bus_req_valid  = (st_q == CS_BUS);
   assign bus_req_write  = wr_q;
   assign bus_req_addr   = addr_q;
   assign cpu_resp_valid = (st_q == CS_RESP);
   assign cpu_resp_hit   = hit_q;

   always_comb begin
      upd_we  = 1'b0;
      upd_idx = addr_q[IDX_W-1:0];
      upd_st  = LS_INV;
      upd_tag = line_tag;
      if (wb_valid && wb_ack) begin
         upd_we = 1'b1;
      end else if ((st_q == CS_BUS) && bus_done) begin
         upd_we  = 1'b1;
         upd_st  = wr_q ? LS_EXC : LS_SHD;
         upd_tag = addr_q[ADDR_W-1:IDX_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= CS_IDLE;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         hit_q     <= 1'b0;
         vic_tag_q <= '0;
      end else begin
         case (st_q)
            CS_IDLE: begin
               if (accept) begin
                  addr_q    <= cpu_req_addr;
                  wr_q      <= cpu_req_write;
                  hit_q     <= is_hit;
                  vic_tag_q <= line_tag;
                  if (is_hit)         st_q <= CS_RESP;
                  else if (dirty_vic) st_q <= CS_WB;
                  else                st_q <= CS_BUS;
               end
            end
            CS_WB: begin
               // a snoop that already flushed the victim withdraws the write-back
               if (!vic_live || wb_ack) st_q <= CS_BUS;
            end
            CS_BUS: begin
               if (bus_done) st_q <= CS_RESP;
            end
            default: begin
               st_q <= CS_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/coh_line_ctl.sv
module coh_line_ctl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LINES  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_ready,
   output logic              cpu_resp_valid,
   output logic              cpu_resp_hit,
   output logic              bus_req_valid,
   output logic              bus_req_write,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_done,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_abort,
   output logic [ADDR_W-1:0] snp_flush_addr
);

   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("coh_line_ctl: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("coh_line_ctl: ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0] look_idx;
   line_st_t         cpu_line_st;
   logic [TAG_W-1:0] cpu_line_tag;
   line_st_t         snp_line_st;
   logic [TAG_W-1:0] snp_line_tag;
   logic             snp_we;
   logic [IDX_W-1:0] snp_idx;
   line_st_t         snp_st;
   logic             cpu_we;
   logic [IDX_W-1:0] cpu_idx;
   line_st_t         cpu_st;
   logic [TAG_W-1:0] cpu_tag;

   coh_line_array #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (look_idx),
      .rd_a_st  (cpu_line_st),
      .rd_a_tag (cpu_line_tag),
      .rd_b_idx (snp_addr[IDX_W-1:0]),
      .rd_b_st  (snp_line_st),
      .rd_b_tag (snp_line_tag),
      .snp_we   (snp_we),
      .snp_idx  (snp_idx),
      .snp_st   (snp_st),
      .cpu_we   (cpu_we),
      .cpu_idx  (cpu_idx),
      .cpu_st   (cpu_st),
      .cpu_tag  (cpu_tag)
   );

   coh_snoop_unit #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) i_snoop (
      .clk            (clk),
      .rst_n          (rst_n),
      .snp_valid      (snp_valid),
      .snp_write      (snp_write),
      .snp_addr       (snp_addr),
      .line_st        (snp_line_st),
      .line_tag       (snp_line_tag),
      .upd_we         (snp_we),
      .upd_idx        (snp_idx),
      .upd_st         (snp_st),
      .snp_abort      (snp_abort),
      .snp_flush_addr (snp_flush_addr)
   );

   coh_cpu_ctl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) i_cpu (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req_valid  (cpu_req_valid),
      .cpu_req_write  (cpu_req_write),
      .cpu_req_addr   (cpu_req_addr),
      .cpu_ready      (cpu_ready),
      .cpu_resp_valid (cpu_resp_valid),
      .cpu_resp_hit   (cpu_resp_hit),
      .bus_req_valid  (bus_req_valid),
      .bus_req_write  (bus_req_write),
      .bus_req_addr   (bus_req_addr),
      .bus_done       (bus_done),
      .wb_valid       (wb_valid),
      .wb_addr        (wb_addr),
      .wb_ack         (wb_ack),
      .snp_valid      (snp_valid),
      .look_idx       (look_idx),
      .line_st        (cpu_line_st),
      .line_tag       (cpu_line_tag),
      .upd_we         (cpu_we),
      .upd_idx        (cpu_idx),
      .upd_st         (cpu_st),
      .upd_tag        (cpu_tag)
   );

endmodule

// File: rtl/coh_line_ctl_chk.sv
module coh_line_ctl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_ready,
   input logic              cpu_resp_valid,
   input logic              cpu_resp_hit,
   input logic              bus_req_valid,
   input logic              bus_req_write,
   input logic [ADDR_W-1:0] bus_req_addr,
   input logic              bus_done,
   input logic              wb_valid,
   input logic              snp_valid,
   input logic              snp_abort
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cpu_resp_valid && !bus_req_valid && !wb_valid && !snp_abort);

   // R4
   hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid && cpu_resp_hit |-> $past(cpu_req_valid && cpu_ready));

   // R7
   abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> $past(snp_valid));

   // R10
   ready_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !snp_valid);

   // R10
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_done |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write));

   // R10
   miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid && !cpu_resp_hit |-> $past(bus_req_valid && bus_done));

   // R11
   one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_resp_valid, bus_req_valid, wb_valid}));

   // R11
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid |=> !cpu_resp_valid);

endmodule

bind coh_line_ctl coh_line_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req_valid  (cpu_req_valid),
   .cpu_ready      (cpu_ready),
   .cpu_resp_valid (cpu_resp_valid),
   .cpu_resp_hit   (cpu_resp_hit),
   .bus_req_valid  (bus_req_valid),
   .bus_req_write  (bus_req_write),
   .bus_req_addr   (bus_req_addr),
   .bus_done       (bus_done),
   .wb_valid       (wb_valid),
   .snp_valid      (snp_valid),
   .snp_abort      (snp_abort)
);

// File: tb/test_coh_line_ctl.sv
`timescale 1ns/1ps
module test_coh_line_ctl;

   localparam int AW = 6;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0;
   logic          cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic          cpu_ready;
   logic          cpu_resp_valid;
   logic          cpu_resp_hit;
   logic          bus_req_valid;
   logic          bus_req_write;
   logic [AW-1:0] bus_req_addr;
   logic          bus_done = 1'b0;
   logic          wb_valid;
   logic [AW-1:0] wb_addr;
   logic          wb_ack = 1'b0;
   logic          snp_valid = 1'b0;
   logic          snp_write = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_abort;
   logic [AW-1:0] snp_flush_addr;

   int n_cmp = 0;
   int n_bad = 0;

   // bench line model: 0 Invalid, 1 Shared, 2 Exclusive
   int         m_st  [NL];
   logic [3:0] m_tag [NL];

   always #10 clk = ~clk;

   coh_line_ctl #(.ADDR_W(AW), .LINES(NL)) i_coh_line_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req_valid  (cpu_req_valid),
      .cpu_req_write  (cpu_req_write),
      .cpu_req_addr   (cpu_req_addr),
      .cpu_ready      (cpu_ready),
      .cpu_resp_valid (cpu_resp_valid),
      .cpu_resp_hit   (cpu_resp_hit),
      .bus_req_valid  (bus_req_valid),
      .bus_req_write  (bus_req_write),
      .bus_req_addr   (bus_req_addr),
      .bus_done       (bus_done),
      .wb_valid       (wb_valid),
      .wb_addr        (wb_addr),
      .wb_ack         (wb_ack),
      .snp_valid      (snp_valid),
      .snp_write      (snp_write),
      .snp_addr       (snp_addr),
      .snp_abort      (snp_abort),
      .snp_flush_addr (snp_flush_addr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input int dly);
      int         ix;
      logic [3:0] tg;
      bit         hit;
      bit         dirty;
      string      rk;
      ix    = int'(a[1:0]);
      tg    = a[5:2];
      hit   = (m_st[ix] != 0) && (m_tag[ix] == tg) && (!wr || m_st[ix] == 2);
      dirty = (m_st[ix] == 2) && (m_tag[ix] != tg);
      rk    = wr ? "R3" : "R2";
      @(negedge clk);
      chk("R10", "cpu_ready idle", 32'(cpu_ready), 32'd1);
      cpu_req_valid = 1'b1;
      cpu_req_write = wr;
      cpu_req_addr  = a;
      @(negedge clk);
      cpu_req_valid = 1'b0;
      if (hit) begin
         chk("R4", "resp_valid", 32'(cpu_resp_valid), 32'd1);
         chk("R4", "resp_hit", 32'(cpu_resp_hit), 32'd1);
         chk("R4", "bus idle on hit", 32'(bus_req_valid), 32'd0);
         chk("R4", "wb idle on hit", 32'(wb_valid), 32'd0);
      end else begin
         if (dirty) begin
            chk("R5", "wb_valid", 32'(wb_valid), 32'd1);
            chk("R5", "wb_addr", 32'(wb_addr), 32'({m_tag[ix], a[1:0]}));
            chk("R5", "bus before wb", 32'(bus_req_valid), 32'd0);
            repeat (dly) @(negedge clk);
            chk("R5", "wb held", 32'(wb_valid), 32'd1);
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            m_st[ix] = 0;
         end
         chk(rk, "bus_req_valid", 32'(bus_req_valid), 32'd1);
         chk(rk, "bus_req_write", 32'(bus_req_write), 32'(wr));
         chk(rk, "bus_req_addr", 32'(bus_req_addr), 32'(a));
         chk("R11", "wb low during bus", 32'(wb_valid), 32'd0);
         repeat (dly) @(negedge clk);
         chk("R10", "bus held", 32'(bus_req_valid), 32'd1);
         chk("R10", "resp withheld", 32'(cpu_resp_valid), 32'd0);
         bus_done = 1'b1;
         @(negedge clk);
         bus_done = 1'b0;
         chk("R10", "miss resp_valid", 32'(cpu_resp_valid), 32'd1);
         chk("R10", "miss resp_hit", 32'(cpu_resp_hit), 32'd0);
         chk("R11", "bus low at resp", 32'(bus_req_valid), 32'd0);
         m_st[ix]  = wr ? 2 : 1;
         m_tag[ix] = tg;
      end
      @(negedge clk);
      chk("R11", "resp one cycle", 32'(cpu_resp_valid), 32'd0);
   endtask

   task automatic snoop(input logic wr, input logic [AW-1:0] a);
      int         ix;
      logic [3:0] tg;
      bit         match;
      bit         ab;
      string      rk;
      ix    = int'(a[1:0]);
      tg    = a[5:2];
      match = (m_st[ix] != 0) && (m_tag[ix] == tg);
      ab    = match && (m_st[ix] == 2);
      if (ab)                               rk = wr ? "R8" : "R7";
      else if (match && wr && m_st[ix] == 1) rk = "R6";
      else                                  rk = "R9";
      @(negedge clk);
      snp_valid     = 1'b1;
      snp_write     = wr;
      snp_addr      = a;
      cpu_req_valid = 1'b1;
      cpu_req_write = 1'b1;
      cpu_req_addr  = a;
      #1;
      chk("R10", "ready low under snoop", 32'(cpu_ready), 32'd0);
      @(negedge clk);
      snp_valid     = 1'b0;
      cpu_req_valid = 1'b0;
      chk(rk, "snp_abort", 32'(snp_abort), 32'(ab));
      if (ab) chk(rk, "snp_flush_addr", 32'(snp_flush_addr), 32'(a));
      chk("R10", "no accept under snoop", 32'(cpu_resp_valid | bus_req_valid | wb_valid), 32'd0);
      if (ab)                                m_st[ix] = wr ? 0 : 1;
      else if (match && wr && m_st[ix] == 1) m_st[ix] = 0;
      @(negedge clk);
      chk(rk, "abort one cycle", 32'(snp_abort), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin
         m_st[i]  = 0;
         m_tag[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cpu_ready", 32'(cpu_ready), 32'd1);
      chk("R1", "resp_valid", 32'(cpu_resp_valid), 32'd0);
      chk("R1", "bus_req_valid", 32'(bus_req_valid), 32'd0);
      chk("R1", "wb_valid", 32'(wb_valid), 32'd0);
      chk("R1", "snp_abort", 32'(snp_abort), 32'd0);
      chk("R1", "snp_flush_addr", 32'(snp_flush_addr), 32'd0);
      // every line starts Invalid: a snoop of tag 0 finds nothing, then reads miss
      for (int i = 0; i < NL; i++) snoop(1'b1, AW'(i));
      for (int i = 0; i < NL; i++) cpu_op(1'b0, AW'(i), i % 3);
      begin
         logic [15:0] lf;
         lf = 16'hACE1;
         for (int n = 0; n < 900; n++) begin
            logic [3:0]    tg;
            logic [AW-1:0] a;
            int            sel;
            sel = int'(lf[5:4]) % 3;
            tg  = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h9 : 4'hF;
            a   = {tg, lf[3:2]};
            case (lf[1:0])
               2'd0: cpu_op(1'b0, a, int'(lf[7:6]) % 3);
               2'd1: cpu_op(1'b1, a, int'(lf[7:6]) % 3);
               2'd2: snoop(1'b0, a);
               default: snoop(1'b1, a);
            endcase
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule